// File: doc/BRIEF.md
# Sample-Stream Pattern and Edge Trigger

This block watches a parallel stream of 16-bit logic samples and decides when an acquisition trigger has occurred. After it is armed, each valid sample is tested against the programmed conditions. When the first sample passes, the block raises a one-cycle trigger pulse and a triggered flag. It also latches the position of that sample, counted in valid samples since arming.

Two kinds of condition exist in normal mode. The first is a level pattern: a value paired with a care mask. The second is edge detection against the previous valid sample, given as a rising-edge mask and a falling-edge mask. Edges are watched on at most two pins, and an edge on either of them counts. The level test and the edge test must both pass on the same sample. In fast mode the level test is bypassed and a packed select byte names one pin and one edge direction. The block also turns a capture ratio in percent into an 8-bit post-trigger depth value for the capture memory controller.

Top module: `trig_detect`

## Requirements
- R1: While reset is held, and on the first cycle after it, trig_pulse, triggered, trig_index and post_depth are all zero, and no sample is evaluated until arm has been pulsed.
- R2: In normal mode the level condition passes when (smp_data AND lvl_mask) equals lvl_value. Bits outside lvl_mask do not matter. Samples presented while not armed never cause a trigger.
- R3: A pin in rise_mask passes its edge test when its bit was 0 in the previous valid sample and is 1 in the current one.
- R4: A pin in fall_mask passes its edge test when its bit was 1 in the previous valid sample and is 0 in the current one.
- R5: In normal mode a trigger needs the level condition and the edge condition to pass on the same sample. With no edge pin programmed, the edge condition always passes.
- R6: The edge-watched pins are the two lowest-numbered set bits of (rise_mask OR fall_mask). An edge on either of them passes the edge condition. Higher set bits have no effect.
- R7: With fast_mode = 1, fast_sel[2:0] names the pin and fast_sel[3] picks the edge (1 = falling, 0 = rising). Level and edge masks have no effect.
- R8: The first valid sample after arming has no predecessor, so no edge condition, in either mode, can pass on it.
- R9: A passing sample presented at a clock edge makes trig_pulse high for exactly the following cycle. triggered rises with it, and trig_index holds the 0-based count of valid samples since arming. Cycles with smp_valid = 0 are not counted.
- R10: Once triggered, further matches are ignored: triggered, trig_index and trig_pulse stay put until arm is pulsed, which clears triggered and restarts the count.
- R11: With lvl_mask, lvl_value, rise_mask and fall_mask all zero in normal mode, the first valid sample after arming triggers with index 0.
- R12: One cycle after capture_ratio is applied, post_depth equals floor(min(capture_ratio,100) × 255 / 100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Pulse to start watching and clear the triggered state |
| smp_valid | input | 1 | smp_data carries a sample this cycle |
| smp_data | input | 16 | Logic sample |
| lvl_value | input | 16 | Level pattern value |
| lvl_mask | input | 16 | Level pattern care mask |
| rise_mask | input | 16 | Pins watched for a rising edge |
| fall_mask | input | 16 | Pins watched for a falling edge |
| fast_mode | input | 1 | 1 selects single-pin fast edge mode |
| fast_sel | input | 8 | Fast mode pin (bits 2:0) and polarity (bit 3) |
| capture_ratio | input | 7 | Post-trigger share in percent |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Trigger has fired since the last arm |
| trig_index | output | 24 | Index of the triggering sample |
| post_depth | output | 8 | Scaled post-trigger depth |

## Verification
The bench targets the first sample after arming. A design that remembered the pre-arm sample as a predecessor would fire an edge on that sample. Three or more edge pins are tested: a design that watched every set bit would fire on a pin that should be ignored, and one that ANDed the two edges would miss a single edge. Fast mode is run with level masks that could never match, which exposes any leak of the level test. Idle cycles are placed between samples, so a counter that advances on invalid cycles reports a wrong index. Ratios above 100 and values that round down check the depth scaling.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_FAST   = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/trig_edge_pick.sv
// Selects the two lowest-numbered set bits of a candidate mask as one-hot vectors.
module trig_edge_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0] cand,
    output logic [W-1:0] pick0,
    output logic [W-1:0] pick1
);

    logic [W-1:0] rest;

    always_comb begin
        pick0 = cand & (~cand + W'(1));
        rest  = cand & ~pick0;
        pick1 = rest & (~rest + W'(1));
    end

endmodule

// File: rtl/trig_cond.sv
// Combinational evaluation of one sample against the programmed conditions.
module trig_cond
    import trig_pkg::*;
#(
    parameter int W     = 16,
    parameter int SEL_W = 8,
    parameter int PIN_W = 3
) (
    input  logic [W-1:0]     cur,
    input  logic [W-1:0]     prev,
    input  logic             has_prev,
    input  logic [W-1:0]     lvl_value,
    input  logic [W-1:0]     lvl_mask,
    input  logic [W-1:0]     rise_mask,
    input  logic [W-1:0]     fall_mask,
    input  trig_mode_e       mode,
    input  logic [SEL_W-1:0] fast_sel,
    output logic             hit
);

    logic [W-1:0] rise_ev;
    logic [W-1:0] fall_ev;
    logic [W-1:0] pick0;
    logic [W-1:0] pick1;
    logic [W-1:0] watched;

    for (genvar p = 0; p < W; p++) begin : g_pin
        assign rise_ev[p] = rise_mask[p] & ~prev[p] &  cur[p];
        assign fall_ev[p] = fall_mask[p] &  prev[p] & ~cur[p];
    end

    trig_edge_pick #(.W(W)) u_pick (
        .cand  (rise_mask | fall_mask),
        .pick0 (pick0),
        .pick1 (pick1)
    );

    logic             lvl_ok;
    logic             edge_ok;
    logic             normal_hit;
    logic [PIN_W-1:0] fpin;
    logic             fpol;
    logic             fast_rise;
    logic             fast_fall;
    logic             fast_hit;

    always_comb begin
        watched    = pick0 | pick1;
        lvl_ok     = ((cur & lvl_mask) == lvl_value);
        if (pick0 == '0) begin
            edge_ok = 1'b1;
        end else begin
            edge_ok = has_prev & (|(watched & (rise_ev | fall_ev)));
        end
        normal_hit = lvl_ok & edge_ok;

        fpin      = fast_sel[PIN_W-1:0];
        fpol      = fast_sel[PIN_W];
        fast_rise = ~prev[fpin] &  cur[fpin];
        fast_fall =  prev[fpin] & ~cur[fpin];
        fast_hit  = has_prev & (fpol ? fast_fall : fast_rise);

        hit = (mode == MODE_FAST) ? fast_hit : normal_hit;
    end

endmodule

// File: rtl/trig_depth.sv
// Scales a percentage to a full-scale depth value, clamping above full scale.
module trig_depth #(
    parameter int RATIO_W    = 7,
    parameter int DEPTH_W    = 8,
    parameter int FULL_SCALE = 100
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic [DEPTH_W-1:0] depth
);

    localparam int PROD_W    = RATIO_W + DEPTH_W;
    localparam int DEPTH_MAX = (1 << DEPTH_W) - 1;

    logic [RATIO_W-1:0] r_clamp;
    logic [PROD_W-1:0]  prod;
    logic [PROD_W-1:0]  quot;

    always_comb begin
        r_clamp = (ratio > RATIO_W'(FULL_SCALE)) ? RATIO_W'(FULL_SCALE) : ratio;
        prod    = PROD_W'(r_clamp) * PROD_W'(DEPTH_MAX);
        quot    = prod / PROD_W'(FULL_SCALE);
        depth   = quot[DEPTH_W-1:0];
    end

endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import trig_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int IDX_W      = 24,
    parameter int SEL_W      = 8,
    parameter int PIN_W      = 3,
    parameter int RATIO_W    = 7,
    parameter int DEPTH_W    = 8,
    parameter int FULL_SCALE = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               smp_valid,
    input  logic [SMP_W-1:0]   smp_data,
    input  logic [SMP_W-1:0]   lvl_value,
    input  logic [SMP_W-1:0]   lvl_mask,
    input  logic [SMP_W-1:0]   rise_mask,
    input  logic [SMP_W-1:0]   fall_mask,
    input  logic               fast_mode,
    input  logic [SEL_W-1:0]   fast_sel,
    input  logic [RATIO_W-1:0] capture_ratio,
    output logic               trig_pulse,
    output logic               triggered,
    output logic [IDX_W-1:0]   trig_index,
    output logic [DEPTH_W-1:0] post_depth
);

    typedef struct packed {
        logic               armed;
        logic               fired;
        logic               pulse;
        logic               has_prev;
        logic [SMP_W-1:0]   prev;
        logic [IDX_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [DEPTH_W-1:0] depth;
    } state_t;

    state_t     st_d;
    state_t     st_q;
    trig_mode_e mode;
    logic       hit;
    logic [DEPTH_W-1:0] depth_calc;

    assign mode = fast_mode ? MODE_FAST : MODE_NORMAL;

    trig_cond #(
        .W     (SMP_W),
        .SEL_W (SEL_W),
        .PIN_W (PIN_W)
    ) u_cond (
        .cur       (smp_data),
        .prev      (st_q.prev),
        .has_prev  (st_q.has_prev),
        .lvl_value (lvl_value),
        .lvl_mask  (lvl_mask),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .mode      (mode),
        .fast_sel  (fast_sel),
        .hit       (hit)
    );

    trig_depth #(
        .RATIO_W    (RATIO_W),
        .DEPTH_W    (DEPTH_W),
        .FULL_SCALE (FULL_SCALE)
    ) u_depth (
        .ratio (capture_ratio),
        .depth (depth_calc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.depth = depth_calc;
        if (arm) begin
            st_d.armed    = 1'b1;
            st_d.fired    = 1'b0;
            st_d.has_prev = 1'b0;
            st_d.cnt      = '0;
            st_d.idx      = '0;
        end else if (smp_valid && st_q.armed && !st_q.fired) begin
            if (hit) begin
                st_d.fired = 1'b1;
                st_d.pulse = 1'b1;
                st_d.idx   = st_q.cnt;
            end
            st_d.prev     = smp_data;
            st_d.has_prev = 1'b1;
            st_d.cnt      = st_q.cnt + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_pulse = st_q.pulse;
    assign triggered  = st_q.fired;
    assign trig_index = st_q.idx;
    assign post_depth = st_q.depth;

endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk #(
    parameter int IDX_W      = 24,
    parameter int RATIO_W    = 7,
    parameter int DEPTH_W    = 8,
    parameter int FULL_SCALE = 100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arm,
    input logic [RATIO_W-1:0] capture_ratio,
    input logic               trig_pulse,
    input logic               triggered,
    input logic [IDX_W-1:0]   trig_index,
    input logic [DEPTH_W-1:0] post_depth
);

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R9
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered);

    // R9
    flag_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> trig_pulse);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered);

    // R10
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> $stable(trig_index));

    // R10
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !triggered);

    // R12
    depth_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_ratio >= RATIO_W'(FULL_SCALE)) |=> (post_depth == {DEPTH_W{1'b1}}));

endmodule

bind trig_detect trig_detect_chk #(
    .IDX_W      (IDX_W),
    .RATIO_W    (RATIO_W),
    .DEPTH_W    (DEPTH_W),
    .FULL_SCALE (FULL_SCALE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .capture_ratio (capture_ratio),
    .trig_pulse    (trig_pulse),
    .triggered     (triggered),
    .trig_index    (trig_index),
    .post_depth    (post_depth)
);

// File: tb/trig_detect_test.sv
module trig_detect_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [15:0] lvl_value = '0;
    logic [15:0] lvl_mask = '0;
    logic [15:0] rise_mask = '0;
    logic [15:0] fall_mask = '0;
    logic        fast_mode = 1'b0;
    logic [7:0]  fast_sel = '0;
    logic [6:0]  capture_ratio = '0;
    logic        trig_pulse;
    logic        triggered;
    logic [23:0] trig_index;
    logic [7:0]  post_depth;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #4 clk = ~clk;

    trig_detect uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm           (arm),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .lvl_value     (lvl_value),
        .lvl_mask      (lvl_mask),
        .rise_mask     (rise_mask),
        .fall_mask     (fall_mask),
        .fast_mode     (fast_mode),
        .fast_sel      (fast_sel),
        .capture_ratio (capture_ratio),
        .trig_pulse    (trig_pulse),
        .triggered     (triggered),
        .trig_index    (trig_index),
        .post_depth    (post_depth)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_armed = 0, m_trig = 0, m_pulse = 0, m_hasprev = 0;
    int m_idx = 0, m_cnt = 0, m_depth = 0;
    bit [15:0] m_prev = '0;

    function automatic bit ref_hit(bit [15:0] cur);
        int pins[$];
        bit edge_ok;
        int p;
        if (fast_mode) begin
            p = int'(fast_sel & 8'h07);
            if (!m_hasprev) return 0;
            if (fast_sel[3]) return m_prev[p] && !cur[p];
            return !m_prev[p] && cur[p];
        end
        for (int i = 0; i < 16; i++)
            if ((rise_mask[i] || fall_mask[i]) && pins.size() < 2) pins.push_back(i);
        if (pins.size() == 0) edge_ok = 1;
        else if (!m_hasprev) edge_ok = 0;
        else begin
            edge_ok = 0;
            foreach (pins[k]) begin
                p = pins[k];
                if (rise_mask[p] && !m_prev[p] && cur[p]) edge_ok = 1;
                if (fall_mask[p] && m_prev[p] && !cur[p]) edge_ok = 1;
            end
        end
        return edge_ok && ((cur & lvl_mask) == lvl_value);
    endfunction

    always @(posedge clk) begin
        int r;
        if (!rst_n) begin
            m_armed = 0; m_trig = 0; m_pulse = 0; m_hasprev = 0;
            m_idx = 0; m_cnt = 0; m_depth = 0; m_prev = '0;
        end else begin
            r = (capture_ratio > 100) ? 100 : int'(capture_ratio);
            m_pulse = 0;
            if (arm) begin
                m_armed = 1; m_trig = 0; m_hasprev = 0; m_cnt = 0; m_idx = 0;
            end else if (smp_valid && m_armed && !m_trig) begin
                if (ref_hit(smp_data)) begin
                    m_trig = 1; m_pulse = 1; m_idx = m_cnt;
                end
                m_prev = smp_data; m_hasprev = 1; m_cnt++;
            end
            m_depth = (r * 255) / 100;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "model trig_pulse", int'(trig_pulse), int'(m_pulse));
            chk(cur_req, "model triggered", int'(triggered), int'(m_trig));
            chk(cur_req, "model trig_index", int'(trig_index), m_idx);
            chk(cur_req, "model post_depth", int'(post_depth), m_depth);
        end
    end

    task automatic step(input bit v, input bit [15:0] d);
        @(negedge clk);
        arm = 0; smp_valid = v; smp_data = d;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1; smp_valid = 0;
    endtask

    task automatic cfg(input bit [15:0] lv, input bit [15:0] lm, input bit [15:0] rm,
                       input bit [15:0] fm, input bit fm_on, input bit [7:0] sel);
        lvl_value = lv; lvl_mask = lm; rise_mask = rm; fall_mask = fm;
        fast_mode = fm_on; fast_sel = sel;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "pulse in reset", int'(trig_pulse), 0);
        chk("R1", "index in reset", int'(trig_index), 0);
        rst_n = 1;
        step(1, 16'h0000);
        step(0, 16'h0000);
        chk("R1", "no trigger before arm", int'(triggered), 0);

        // R2 level match, pre-arm samples ignored
        cur_req = "R2";
        cfg(16'h00A5, 16'h00FF, 0, 0, 0, 0);
        step(1, 16'h00A5);
        step(0, 0);
        chk("R2", "unarmed match ignored", int'(triggered), 0);
        do_arm();
        step(1, 16'h1234);
        step(1, 16'h12A4);
        step(0, 0);
        step(1, 16'hFFA5);
        step(0, 0);
        chk("R2", "level pulse", int'(trig_pulse), 1);
        chk("R9", "index skips idle", int'(trig_index), 2);
        cur_req = "R9";
        step(0, 0);
        chk("R9", "pulse one cycle", int'(trig_pulse), 0);
        chk("R9", "flag held", int'(triggered), 1);

        // R10 ignore after fire, re-arm clears
        cur_req = "R10";
        step(1, 16'h00A5);
        step(1, 16'h00A5);
        step(0, 0);
        chk("R10", "no second pulse", int'(trig_pulse), 0);
        chk("R10", "index kept", int'(trig_index), 2);
        do_arm();
        step(0, 0);
        chk("R10", "arm clears flag", int'(triggered), 0);

        // R3 rising, R8 first sample
        cur_req = "R8";
        cfg(0, 0, 16'h0008, 0, 0, 0);
        do_arm();
        step(1, 16'h0008);
        step(0, 0);
        chk("R8", "no edge on first sample", int'(triggered), 0);
        cur_req = "R3";
        step(1, 16'h0000);
        step(1, 16'h0008);
        step(0, 0);
        chk("R3", "rising fires", int'(trig_pulse), 1);
        chk("R3", "rising index", int'(trig_index), 2);

        // R4 falling
        cur_req = "R4";
        cfg(0, 0, 0, 16'h0001, 0, 0);
        do_arm();
        step(1, 16'h0000);
        step(1, 16'h0001);
        step(1, 16'h0000);
        step(0, 0);
        chk("R4", "falling index", int'(trig_index), 2);
        chk("R4", "falling flag", int'(triggered), 1);

        // R5 level AND edge
        cur_req = "R5";
        cfg(16'h0500, 16'h0F00, 16'h0001, 0, 0, 0);
        do_arm();
        step(1, 16'h0000);
        step(1, 16'h0001);
        step(1, 16'h0000);
        step(1, 16'h0501);
        step(0, 0);
        chk("R5", "needs both", int'(trig_index), 3);

        // R6 two lowest pins, ORed
        cur_req = "R6";
        cfg(0, 0, 16'h0032, 0, 0, 0);
        do_arm();
        step(1, 16'h0000);
        step(1, 16'h0020);
        step(1, 16'h0000);
        step(1, 16'h0010);
        step(0, 0);
        chk("R6", "third pin ignored, second fires", int'(trig_index), 3);

        // R7 fast mode
        cur_req = "R7";
        cfg(16'h1234, 16'hFFFF, 0, 0, 1, 8'h0B);
        do_arm();
        step(1, 16'h0000);
        step(1, 16'h0008);
        step(1, 16'h0000);
        step(0, 0);
        chk("R7", "fast falling pin3", int'(trig_index), 2);
        cfg(16'h1234, 16'hFFFF, 0, 0, 1, 8'h05);
        do_arm();
        step(1, 16'h0020);
        step(1, 16'h0000);
        step(1, 16'h0020);
        step(0, 0);
        chk("R7", "fast rising pin5", int'(trig_index), 2);
        chk("R7", "fast flag", int'(triggered), 1);

        // R11 empty masks
        cur_req = "R11";
        cfg(0, 0, 0, 0, 0, 0);
        do_arm();
        step(0, 0);
        step(0, 0);
        step(1, 16'hBEEF);
        step(0, 0);
        chk("R11", "first valid fires", int'(trig_pulse), 1);
        chk("R11", "index zero", int'(trig_index), 0);

        // R12 depth scaling
        cur_req = "R12";
        capture_ratio = 7'd0;   step(0, 0); step(0, 0);
        chk("R12", "ratio 0", int'(post_depth), 0);
        capture_ratio = 7'd50;  step(0, 0); step(0, 0);
        chk("R12", "ratio 50", int'(post_depth), 127);
        capture_ratio = 7'd33;  step(0, 0); step(0, 0);
        chk("R12", "ratio 33", int'(post_depth), 84);
        capture_ratio = 7'd100; step(0, 0); step(0, 0);
        chk("R12", "ratio 100", int'(post_depth), 255);
        capture_ratio = 7'd127; step(0, 0); step(0, 0);
        chk("R12", "ratio clamp", int'(post_depth), 255);

        // Mixed random traffic against the model
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            if (i % 50 == 0) begin
                cfg(16'($urandom) & 16'h000F, 16'($urandom) & 16'h000F,
                    16'($urandom) & 16'h00F3, 16'($urandom) & 16'h003C,
                    ($urandom % 4) == 0, 8'($urandom));
                lvl_value = lvl_value & lvl_mask;
                capture_ratio = 7'($urandom);
                do_arm();
            end else begin
                step(($urandom % 4) != 0, 16'($urandom) & 16'h00FF);
            end
        end
        step(0, 0);
        step(0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule